// File: doc/BRIEF.md
# Round-Robin Arbiter with Masked Priority Encoding

This block picks one winner among N request lines every cycle and rotates priority among them in round-robin order. A stored pointer names the line that currently holds top priority. The grant goes to the first active request at or above the pointer, wrapping to the low end of the vector if nothing at or above it is active. The path from requests to grant is purely combinational, so a grant appears in the same cycle as the request that earns it.

The priority is made programmable without rotating the request vector. A thermometer code of the pointer blanks every line below it. Two fixed lowest-index-first encoders then run side by side: one on the blanked vector and one on the raw vector. The blanked result wins when it finds anything. Otherwise the raw result is used. The two results are merged with a plain OR.

The pointer moves only when the surrounding logic raises the update enable. It then lands one position past the granted line, modulo N. With the enable low, the same priority order carries over to the next cycle. This lets a matching scheduler commit pointer moves only for grants that were accepted. Deciding when to raise the enable is left to that scheduler.

Top module: `rr_mask_arbiter`

## Requirements
- R1: Reset, active low and asynchronous, sets the priority pointer to index 0. With all requests high after reset, the grant is bit 0.
- R2: The grant is the first asserted request found by scanning upward from the pointer index, wrapping from N-1 back to 0.
- R3: An asserted request at or above the pointer beats any asserted request below the pointer, even one with a lower index.
- R4: When no request is asserted at or above the pointer, the lowest-index asserted request wins.
- R5: The grant vector is either all zero or has exactly one bit set, and that bit is always an asserted request.
- R6: `gnt_any` is high exactly when at least one request bit is high.
- R7: On a clock edge with `upd_en` high and a grant present at index k, the pointer becomes k+1. It wraps to 0 when k is N-1.
- R8: On a clock edge with `upd_en` low, the pointer keeps its value.
- R9: With no request asserted, the grant is all zero and the pointer keeps its value even if `upd_en` is high.
- R10: The grant follows a change of the request vector in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request lines, one per requester |
| upd_en | input | 1 | Allows the pointer to advance past the current grant |
| gnt | output | N | Grant vector, one-hot or all zero |
| gnt_any | output | 1 | High when some request is granted |

## Verification
The pointer is internal, so a wrong pointer only shows up at the grant port. It appears in the first cycle in which the requests are spread on both sides of the true pointer. Until then, a fault can hide behind request patterns with a single active line. For this reason the random stimulus keeps most request vectors dense. It also mixes enable-high and enable-low cycles, so that a pointer that moved wrongly, or failed to move, is exposed within a cycle or two. Directed cases cover the wrap at the top index, the empty request vector with the enable high, and the masked lines losing to higher-index lines.

// File: rtl/rr_mask_arbiter.sv
module rr_mask_arbiter #(
  parameter int N  = 8,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         upd_en,
  output logic [N-1:0] gnt,
  output logic         gnt_any
);

  logic [PW-1:0] ptr;
  logic [PW-1:0] gidx;
  logic [PW-1:0] ptr_nxt;
  logic [N-1:0]  therm;
  logic [N-1:0]  req_hi;
  logic [N-1:0]  gnt_hi;
  logic [N-1:0]  gnt_lo;
  logic          hi_found;

  for (genvar i = 0; i < N; i++) begin : g_therm
    assign therm[i] = (ptr > PW'(i));
  end

  assign req_hi   = req & ~therm;
  assign gnt_hi   = req_hi & (~req_hi + N'(1));
  assign gnt_lo   = req & (~req + N'(1));
  assign hi_found = |req_hi;
  assign gnt      = gnt_hi | (gnt_lo & {N{~hi_found}});
  assign gnt_any  = |req;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) gidx = gidx | PW'(i);
  end

  assign ptr_nxt = (gidx == PW'(N-1)) ? '0 : gidx + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (upd_en && gnt_any)
      ptr <= ptr_nxt;
  end

endmodule

// File: rtl/rr_mask_arbiter_chk.sv
module rr_mask_arbiter_chk #(
  parameter int N  = 8,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          upd_en,
  input logic [N-1:0]  gnt,
  input logic          gnt_any,
  input logic [PW-1:0] ptr,
  input logic [PW-1:0] gidx
);

  assert_reset_ptr_R1: assert property (@(posedge clk)
    !rst_n |=> ptr == '0);

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_gnt_in_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  assert_any_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any == (gnt != '0));

  assert_req_gets_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> $countones(gnt) == 1);

  assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && req != '0) |=> int'(ptr) == (int'($past(gidx)) + 1) % N);

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ptr));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> $stable(ptr));

endmodule

bind rr_mask_arbiter rr_mask_arbiter_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .upd_en(upd_en),
  .gnt(gnt), .gnt_any(gnt_any), .ptr(ptr), .gidx(gidx)
);

// File: tb/sim_rr_mask_arbiter.sv
`timescale 1ns/1ps
module sim_rr_mask_arbiter;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         upd_en = 1'b0;
  logic [N-1:0] gnt;
  logic         gnt_any;

  int n_chk = 0;
  int n_fail = 0;
  int mptr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rr_mask_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .upd_en(upd_en),
    .gnt(gnt), .gnt_any(gnt_any)
  );

  function automatic logic [N-1:0] exp_gnt(logic [N-1:0] r, int p);
    for (int k = 0; k < N; k++) begin
      int j = (p + k) % N;
      if (r[j]) return N'(1) << j;
    end
    return '0;
  endfunction

  function automatic int idx_of(logic [N-1:0] g);
    for (int k = 0; k < N; k++) if (g[k]) return k;
    return -1;
  endfunction

  task automatic step(input logic [N-1:0] r, input logic u, input string tag);
    logic [N-1:0] eg;
    @(negedge clk);
    req = r;
    upd_en = u;
    #1;
    eg = exp_gnt(r, mptr);
    n_chk++;
    if (gnt !== eg) begin
      n_fail++;
      $display("FAIL %s grant req=%b actual=%b expected=%b", tag, r, gnt, eg);
    end
    n_chk++;
    if (gnt_any !== (r != '0)) begin
      n_fail++;
      $display("FAIL R6 gnt_any req=%b actual=%b expected=%b", r, gnt_any, (r != '0));
    end
    n_chk++;
    if (!$onehot0(gnt) || (gnt & ~r) != '0) begin
      n_fail++;
      $display("FAIL R5 grant shape req=%b actual=%b expected=%b", r, gnt, eg);
    end
    if (u && r != '0) mptr = (idx_of(eg) + 1) % N;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step(8'hFF, 1'b0, "R1");
    step(8'hFF, 1'b1, "R7");
    step(8'hFF, 1'b0, "R2");
    step(8'h01, 1'b0, "R4");
    step(8'h81, 1'b0, "R3");
    step(8'h10, 1'b1, "R10");
    step(8'h21, 1'b0, "R3");
    step(8'h0F, 1'b0, "R4");
    step(8'h80, 1'b1, "R7");
    step(8'hFF, 1'b0, "R7");
    step(8'h00, 1'b1, "R9");
    step(8'hFE, 1'b0, "R9");
    step(8'h40, 1'b0, "R8");
    step(8'hFF, 1'b0, "R8");
    step(8'h04, 1'b1, "R7");
    step(8'h0B, 1'b1, "R4");

    for (int i = 0; i < 3000; i++) begin
      r = N'($urandom);
      if ($urandom_range(3) == 0) r = r & N'($urandom);
      if ($urandom_range(15) == 0) r = '0;
      step(r, 1'($urandom_range(1)), "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule